// File: doc/BRIEF.md
# Packed Dual-View Depth Memory

This block stores a small depth (priority) value for every display pixel and presents that storage in two shapes. The processor or blitter sees 32-bit words. Each word packs either sixteen 2-bit or eight 4-bit depth values, and byte enables allow partial updates. The display pipeline presents a pixel index and receives that pixel's depth value one cycle later. Internally the block reads a byte and uses a field multiplexer, steered by the pixel index and the active depth width, to extract the value.

The bus port is shared with the color frame buffer. A buffer-select flag that comes with each access decides where it goes. With the flag low, the access passes straight through to the frame-buffer side, and the read data returned is the frame buffer's. With the flag high, the access lands in the depth memory. Drawing hardware can therefore produce one address stream for both surfaces.

The depth memory's read ports are enabled only when work is due. The display read is disabled during vertical blank, and the bus read register loads only on a depth read. The depth width is a single configuration bit, and it is taken only at a frame-start strobe.

Top module: `zbuf_dualview`

## Requirements
- R1: A bus write with the flag high updates only the byte lanes whose enable bit is set (bit n covers data bits 8n+7..8n), and the other packed fields of that word keep their contents.
- R2: A depth read (request high, write low, flag high) shows the addressed word on `bus_rdata` in the cycle after the request. The value then holds through idle cycles and through depth writes until the next read.
- R3: With the flag low, `fb_req`, `fb_we`, `fb_addr`, `fb_be` and `fb_wdata` follow the bus inputs in the same cycle, and the depth memory is left unchanged. After such a read, `bus_rdata` shows `fb_rdata`.
- R4: `fb_req` stays low whenever the access is steered to the depth memory.
- R5: In 2-bit mode (mode bit 0), pixel p reads bits 2*(p mod 16)+1..2*(p mod 16) of word p/16, zero-extended to 4 bits. The lowest pixel index takes the least significant field.
- R6: In 4-bit mode (mode bit 1), pixel p reads bits 4*(p mod 8)+3..4*(p mod 8) of word p/8.
- R7: `disp_depth` shows the value for the pixel index presented one clock earlier.
- R8: While `vblank` is high, no display read takes place and `disp_depth` holds its value, whatever `pix_addr` does.
- R9: The mode bit is taken only in a cycle with `frame_start` high. Changes of `mode_cfg` at other times have no effect.
- R10: After reset, `bus_rdata` and `disp_depth` are zero, `fb_req` is low and the mode is 2-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_sel_depth | input | 1 | Buffer-select flag: 1 = depth memory, 0 = frame buffer |
| bus_addr | input | WORD_AW | Word address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read |
| fb_req | output | 1 | Frame-buffer access strobe |
| fb_we | output | 1 | Frame-buffer write |
| fb_addr | output | WORD_AW | Frame-buffer word address |
| fb_be | output | 4 | Frame-buffer byte enables |
| fb_wdata | output | 32 | Frame-buffer write data |
| fb_rdata | input | 32 | Frame-buffer read data |
| frame_start | input | 1 | Start-of-frame strobe that loads the mode bit |
| mode_cfg | input | 1 | Depth width: 0 = 2-bit, 1 = 4-bit |
| vblank | input | 1 | Vertical blank; display reads stop |
| pix_addr | input | WORD_AW+4 | Pixel index for the display read |
| disp_depth | output | 4 | Depth value of the pixel presented last cycle |

## Verification
The assertions assume that the frame-buffer read data changes only as the system drives it, and that `bus_req` is high for one cycle for each access. They also assume that a bus write and a display read never target the same word in the same edge, because the display view of such a collision is not defined. The stimulus keeps to these limits in three ways. It applies every input change on the falling edge and holds each request for exactly one cycle. It keeps `fb_rdata` constant. It loads the depth words before any display read touches them and never overlaps a write with a display read. Mode changes are applied only inside vertical blank, together with a frame-start pulse, so no display read is in flight when the width changes.

// File: rtl/zbuf_pkg.sv
package zbuf_pkg;

    typedef enum logic {
        ZW_TWO  = 1'b0,
        ZW_FOUR = 1'b1
    } zwidth_e;

    // Selection captured alongside a display read
    typedef struct packed {
        logic [1:0] lane;
        logic [1:0] field;
        zwidth_e    width;
    } dsel_t;

    localparam int BUS_W  = 32;
    localparam int LANE_N = BUS_W / 8;

    function automatic logic [3:0] pick_depth(
        input logic [7:0] b,
        input logic [1:0] f,
        input zwidth_e    w
    );
        if (w == ZW_FOUR)
            return f[0] ? b[7:4] : b[3:0];
        else
            return {2'b00, b[{f, 1'b0} +: 2]};
    endfunction

endpackage

// File: rtl/zb_lane_ram.sv
module zb_lane_ram #(
    parameter int WORD_AW = 8,
    localparam int WORDS = 1 << WORD_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [WORD_AW-1:0] wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               brd_en,
    input  logic [WORD_AW-1:0] brd_addr,
    output logic [7:0]         brd_q,
    input  logic               drd_en,
    input  logic [WORD_AW-1:0] drd_addr,
    output logic [7:0]         drd_q
);
    logic [7:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            brd_q <= '0;
            drd_q <= '0;
        end else begin
            if (brd_en)
                brd_q <= mem[brd_addr];
            if (drd_en)
                drd_q <= mem[drd_addr];
        end
    end
endmodule

// File: rtl/zb_bus_steer.sv
module zb_bus_steer
    import zbuf_pkg::*;
#(
    parameter int WORD_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic               bus_sel_depth,
    input  logic [WORD_AW-1:0] bus_addr,
    input  logic [LANE_N-1:0]  bus_be,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               fb_req,
    output logic               fb_we,
    output logic [WORD_AW-1:0] fb_addr,
    output logic [LANE_N-1:0]  fb_be,
    output logic [BUS_W-1:0]   fb_wdata,
    input  logic [BUS_W-1:0]   fb_rdata,
    input  logic [BUS_W-1:0]   z_rdata,
    output logic               z_rd_en,
    output logic [LANE_N-1:0]  z_wr_en
);
    logic z_ce;
    logic route_z_q;

    assign z_ce    = bus_req & bus_sel_depth;
    assign z_rd_en = z_ce & ~bus_we;
    assign z_wr_en = (z_ce & bus_we) ? bus_be : '0;

    assign fb_req   = bus_req & ~bus_sel_depth;
    assign fb_we    = fb_req & bus_we;
    assign fb_addr  = bus_addr;
    assign fb_be    = bus_be;
    assign fb_wdata = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst)
            route_z_q <= 1'b1;
        else if (bus_req && !bus_we)
            route_z_q <= bus_sel_depth;
    end

    assign bus_rdata = route_z_q ? z_rdata : fb_rdata;
endmodule

// File: rtl/zb_pix_map.sv
module zb_pix_map
    import zbuf_pkg::*;
#(
    parameter int WORD_AW = 8,
    localparam int PIX_W = WORD_AW + 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               mode_cfg,
    input  logic               vblank,
    input  logic [PIX_W-1:0]   pix_addr,
    output logic               rd_en,
    output logic [WORD_AW-1:0] rd_addr,
    output dsel_t              sel_q
);
    localparam int BYTE_AW = WORD_AW + 2;

    zwidth_e            mode_q;
    logic [BYTE_AW-1:0] byte_a;
    logic [1:0]         field;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= ZW_TWO;
        else if (frame_start)
            mode_q <= zwidth_e'(mode_cfg);
    end

    always_comb begin
        if (mode_q == ZW_FOUR) begin
            byte_a = pix_addr[BYTE_AW:1];
            field  = {1'b0, pix_addr[0]};
        end else begin
            byte_a = pix_addr[BYTE_AW+1:2];
            field  = pix_addr[1:0];
        end
    end

    assign rd_en   = ~vblank;
    assign rd_addr = byte_a[BYTE_AW-1:2];

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (rd_en)
            sel_q <= '{lane: byte_a[1:0], field: field, width: mode_q};
    end
endmodule

// File: rtl/zbuf_dualview.sv
module zbuf_dualview
    import zbuf_pkg::*;
#(
    parameter int WORD_AW = 8,
    localparam int PIX_W = WORD_AW + 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic               bus_sel_depth,
    input  logic [WORD_AW-1:0] bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               fb_req,
    output logic               fb_we,
    output logic [WORD_AW-1:0] fb_addr,
    output logic [3:0]         fb_be,
    output logic [31:0]        fb_wdata,
    input  logic [31:0]        fb_rdata,
    input  logic               frame_start,
    input  logic               mode_cfg,
    input  logic               vblank,
    input  logic [PIX_W-1:0]   pix_addr,
    output logic [3:0]         disp_depth
);
    logic [BUS_W-1:0]   z_rdata;
    logic               z_rd_en;
    logic [LANE_N-1:0]  z_wr_en;
    logic               d_rd_en;
    logic [WORD_AW-1:0] d_rd_addr;
    dsel_t              d_sel;
    logic [7:0]         d_bytes [LANE_N];

    zb_bus_steer #(.WORD_AW(WORD_AW)) u_steer (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_sel_depth(bus_sel_depth),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .fb_req(fb_req), .fb_we(fb_we), .fb_addr(fb_addr), .fb_be(fb_be),
        .fb_wdata(fb_wdata), .fb_rdata(fb_rdata),
        .z_rdata(z_rdata), .z_rd_en(z_rd_en), .z_wr_en(z_wr_en)
    );

    zb_pix_map #(.WORD_AW(WORD_AW)) u_pix (
        .clk(clk), .rst(rst),
        .frame_start(frame_start), .mode_cfg(mode_cfg), .vblank(vblank),
        .pix_addr(pix_addr),
        .rd_en(d_rd_en), .rd_addr(d_rd_addr), .sel_q(d_sel)
    );

    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        zb_lane_ram #(.WORD_AW(WORD_AW)) u_ram (
            .clk(clk), .rst(rst),
            .wr_en(z_wr_en[g]), .wr_addr(bus_addr), .wr_data(bus_wdata[8*g +: 8]),
            .brd_en(z_rd_en), .brd_addr(bus_addr), .brd_q(z_rdata[8*g +: 8]),
            .drd_en(d_rd_en), .drd_addr(d_rd_addr), .drd_q(d_bytes[g])
        );
    end

    assign disp_depth = pick_depth(d_bytes[d_sel.lane], d_sel.field, d_sel.width);
endmodule

// File: rtl/zbuf_dualview_chk.sv
module zbuf_dualview_chk #(
    parameter int WORD_AW = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_req,
    input logic               bus_we,
    input logic               bus_sel_depth,
    input logic [WORD_AW-1:0] bus_addr,
    input logic [31:0]        bus_rdata,
    input logic               fb_req,
    input logic               fb_we,
    input logic [WORD_AW-1:0] fb_addr,
    input logic [31:0]        fb_rdata,
    input logic               vblank,
    input logic [3:0]         disp_depth
);
    assert_fb_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_sel_depth) |-> !fb_req);

    assert_fb_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_sel_depth) |-> (fb_req && fb_addr == bus_addr));

    assert_fb_we_qual_R3: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (fb_req && bus_we));

    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!bus_req || bus_we) |=> ($stable(bus_rdata) || !$stable(fb_rdata)));

    assert_vblank_hold_R8: assert property (@(posedge clk) disable iff (rst)
        vblank |=> $stable(disp_depth));
endmodule

bind zbuf_dualview zbuf_dualview_chk #(.WORD_AW(WORD_AW)) u_chk (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_sel_depth(bus_sel_depth),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .fb_req(fb_req), .fb_we(fb_we), .fb_addr(fb_addr), .fb_rdata(fb_rdata),
    .vblank(vblank), .disp_depth(disp_depth)
);

// File: tb/test_zbuf_dualview.sv
module test_zbuf_dualview;
    localparam int AW = 8;
    localparam int PW = AW + 4;
    localparam logic [31:0] FB_DATA = 32'hCAFE_F00D;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_req = 1'b0, bus_we = 1'b0, bus_sel_depth = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0]    bus_be = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          fb_req, fb_we;
    logic [AW-1:0] fb_addr;
    logic [3:0]    fb_be;
    logic [31:0]   fb_wdata;
    logic [31:0]   fb_rdata = FB_DATA;
    logic          frame_start = 1'b0, mode_cfg = 1'b0, vblank = 1'b1;
    logic [PW-1:0] pix_addr = '0;
    logic [3:0]    disp_depth;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit cur_mode = 0;

    always #10 clk = ~clk;

    zbuf_dualview #(.WORD_AW(AW)) i_zbuf_dualview (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_sel_depth(bus_sel_depth),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .fb_req(fb_req), .fb_we(fb_we), .fb_addr(fb_addr), .fb_be(fb_be),
        .fb_wdata(fb_wdata), .fb_rdata(fb_rdata),
        .frame_start(frame_start), .mode_cfg(mode_cfg), .vblank(vblank),
        .pix_addr(pix_addr), .disp_depth(disp_depth)
    );

    // {mode, pixel, expected}; words 0/1 hold 7654_3210 and FEDC_BA98
    localparam logic [16:0] VEC [12] = '{
        {1'b1, 12'd0,  4'h0}, {1'b1, 12'd7,  4'h7}, {1'b1, 12'd8,  4'h8},
        {1'b1, 12'd15, 4'hF}, {1'b1, 12'd9,  4'h9},
        {1'b0, 12'd0,  4'h0}, {1'b0, 12'd5,  4'h0}, {1'b0, 12'd6,  4'h3},
        {1'b0, 12'd15, 4'h1}, {1'b0, 12'd17, 4'h2}, {1'b0, 12'd30, 4'h3},
        {1'b0, 12'd31, 4'h3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [AW-1:0] a,
                             input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_sel_depth = sel;
        bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0; bus_sel_depth = 1;
    endtask

    task automatic bus_read(input logic sel, input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_sel_depth = sel; bus_addr = a;
        @(negedge clk);
        bus_req = 0; bus_sel_depth = 1;
        d = bus_rdata;
    endtask

    task automatic set_mode(input bit m);
        @(negedge clk);
        vblank = 1; mode_cfg = m; frame_start = 1;
        @(negedge clk);
        frame_start = 0;
        @(negedge clk);
        vblank = 0;
        cur_mode = m;
    endtask

    task automatic disp_check(input string req, input logic [PW-1:0] p, input logic [3:0] exp);
        @(negedge clk);
        pix_addr = p;
        @(negedge clk);
        check(req, {28'd0, disp_depth}, {28'd0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        check("R10 rdata", bus_rdata, 32'h0);
        check("R10 depth", {28'd0, disp_depth}, 32'h0);
        check("R10 fb_req", {31'd0, fb_req}, 32'h0);

        // R4: no frame-buffer strobe during depth access
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_sel_depth = 1; bus_addr = 0; bus_be = 4'hF;
        bus_wdata = 32'h7654_3210;
        #1 check("R4 fb quiet", {31'd0, fb_req}, 32'h0);
        @(negedge clk);
        bus_req = 0; bus_we = 0;
        bus_write(1, 1, 4'hF, 32'hFEDC_BA98);

        // R1/R2 full-word readback
        bus_read(1, 0, rd);
        check("R2 read word0", rd, 32'h7654_3210);
        bus_read(1, 1, rd);
        check("R2 read word1", rd, 32'hFEDC_BA98);

        // R2 hold through idle and a depth write
        repeat (2) @(negedge clk);
        bus_write(1, 3, 4'hF, 32'h1111_2222);
        check("R2 hold", bus_rdata, 32'hFEDC_BA98);

        // R1 byte enables
        bus_write(1, 2, 4'hF, 32'hFFFF_FFFF);
        bus_write(1, 2, 4'b0101, 32'h0000_0000);
        bus_read(1, 2, rd);
        check("R1 byte enables", rd, 32'hFF00_FF00);

        // R3 steering to frame buffer
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_sel_depth = 0; bus_addr = 0; bus_be = 4'h9;
        bus_wdata = 32'h1234_5678;
        #1;
        check("R3 fb_req", {31'd0, fb_req}, 32'h1);
        check("R3 fb_we", {31'd0, fb_we}, 32'h1);
        check("R3 fb_addr", {24'd0, fb_addr}, 32'h0);
        check("R3 fb_be", {28'd0, fb_be}, 32'h9);
        check("R3 fb_wdata", fb_wdata, 32'h1234_5678);
        @(negedge clk);
        bus_req = 0; bus_we = 0; bus_sel_depth = 1;
        bus_read(1, 0, rd);
        check("R3 depth untouched", rd, 32'h7654_3210);
        bus_read(0, 0, rd);
        check("R3 fb read data", rd, FB_DATA);

        // R5/R6/R7 display view table
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][16] != cur_mode)
                set_mode(VEC[i][16]);
            disp_check(VEC[i][16] ? "R6 4-bit R7" : "R5 2-bit R7",
                       VEC[i][15:4], VEC[i][3:0]);
        end

        // R9 mode ignored without frame_start
        set_mode(1);
        @(negedge clk);
        mode_cfg = 0;
        disp_check("R9 mode held", 12'd9, 4'h9);

        // R8 hold during vblank
        disp_check("R8 pre", 12'd7, 4'h7);
        @(negedge clk);
        vblank = 1; pix_addr = 12'd3;
        @(negedge clk);
        @(negedge clk);
        check("R8 vblank hold", {28'd0, disp_depth}, 32'h7);
        vblank = 0;
        disp_check("R7 after blank", 12'd3, 4'h3);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule